// File: doc/BRIEF.md
# Four-Pin GPIO Port Slice with Prioritised Alternate Functions

This block is one slice of a general-purpose I/O port. It has four pins. A small register bus reaches two registers. The data latch holds the value that each pin drives while it is used as general-purpose I/O. The direction register chooses, per pin, whether general-purpose mode drives the pad or only observes it. A read of the data register returns one of two values per bit. Output pins return the latch bit. Input pins return the buffered pad level.

Each pin can also be claimed by peripherals, and a fixed order decides which one drives the pad:

- A timer channel has first claim on every pin.
- A PWM channel comes second on every pin.
- On pin 1, a serial transmitter comes next.
- On pin 0, a serial receiver comes next. When the receiver owns pin 0, the pad becomes an input.

General-purpose I/O gets a pin only when no enabled peripheral claims it. The owning peripheral also sets the pad output enable.

The data latch has no reset, so software values survive a reset. The direction register clears on reset, so pins start as inputs.

Top module: `gpio_alt_port`

## Requirements
- R1: The data register at bus offset 0x250 can be written and read in any cycle. A write of bits 3:0 updates the latch on the clock edge of the write.
- R2: Data-register bits 7:4 always read as 0. Writes to those bits have no effect.
- R3: Reset does not change the data latch. After reset, with direction set to output, a read returns the value written before the reset.
- R4: The direction register at offset 0x252 (bit n = pin n, 1 = output) resets to 0. With no peripheral enabled, every pad output enable is then 0.
- R5: A read of data bit n returns the latch bit when direction bit n is 1. It returns pad_in_i[n] when direction bit n is 0.
- R6: A pin with no enabled peripheral drives pad_out_o[n] from latch bit n and pad_oe_o[n] from direction bit n.
- R7: An enabled timer channel on pin n drives pad_out_o[n] from tmr_out_i[n] with pad_oe_o[n]=1. This overrides PWM, serial and GPIO.
- R8: An enabled PWM channel on pin n, with its timer channel disabled, drives pad_out_o[n] from pwm_out_i[n] with pad_oe_o[n]=1. This overrides serial and GPIO.
- R9: On pin 1, with timer and PWM disabled, an asserted ser_tx_en_i drives pad_out_o[1] from ser_tx_i with pad_oe_o[1]=1.
- R10: On pin 0, with timer and PWM disabled, an asserted ser_rx_en_i gives pad_oe_o[0]=0 and pad_out_o[0]=0. ser_rx_o always equals pad_in_i[0].
- R11: A data-register write while a peripheral owns the pin still updates the latch. The new value drives the pin once the pin returns to GPIO.
- R12: A read of any offset other than the two registers returns 0. A write there changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 12 | Register offset |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pad_in_i | input | 4 | Buffered pad levels |
| pad_out_o | output | 4 | Pad output values |
| pad_oe_o | output | 4 | Pad output enables |
| tmr_en_i | input | 4 | Timer channel enables per pin |
| tmr_out_i | input | 4 | Timer output levels per pin |
| pwm_en_i | input | 4 | PWM channel enables per pin |
| pwm_out_i | input | 4 | PWM output levels per pin |
| ser_tx_en_i | input | 1 | Serial transmit enable (pin 1) |
| ser_tx_i | input | 1 | Serial transmit data |
| ser_rx_en_i | input | 1 | Serial receive enable (pin 0) |
| ser_rx_o | output | 1 | Serial receive data from pin 0 |

## Verification
The checker assumes that bus inputs are stable and known around each rising clock edge. It also assumes that a data write is followed at once by a read that looks at the same offset. The stimulus changes bus and peripheral inputs only on falling edges. No write is issued before reset has been released. The priority checks take peripheral enables as known values. The bench drives every enable to a defined level from time zero.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    OWN_GPIO,
    OWN_TMR,
    OWN_PWM,
    OWN_TX,
    OWN_RX
  } owner_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int          NPINS     = 4,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 8,
  parameter logic [11:0] DATA_ADDR = 12'h250,
  parameter logic [11:0] DIR_ADDR  = 12'h252
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  data_q_o,
  output logic [NPINS-1:0]  dir_q_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int PAD_W = DATA_W - NPINS;

  logic hit_data, hit_dir;
  assign hit_data = (addr_i == ADDR_W'(DATA_ADDR));
  assign hit_dir  = (addr_i == ADDR_W'(DIR_ADDR));

  // data latch has no reset by intent
  always_ff @(posedge clk_i) begin
    if (we_i && hit_data) data_q_o <= wdata_i[NPINS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                dir_q_o <= '0;
    else if (we_i && hit_dir)   dir_q_o <= wdata_i[NPINS-1:0];
  end

  logic [NPINS-1:0] data_rd;
  assign data_rd = (data_q_o & dir_q_o) | (pad_in_i & ~dir_q_o);

  always_comb begin
    rdata_o = '0;
    if (hit_data)     rdata_o = {{PAD_W{1'b0}}, data_rd};
    else if (hit_dir) rdata_o = {{PAD_W{1'b0}}, dir_q_o};
  end

  logic unused_w;
  assign unused_w = ^wdata_i[DATA_W-1:NPINS];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_port_pkg::*;
(
  input  logic gpio_out_i,
  input  logic gpio_oe_i,
  input  logic tmr_en_i,
  input  logic tmr_out_i,
  input  logic pwm_en_i,
  input  logic pwm_out_i,
  input  logic tx_en_i,
  input  logic tx_i,
  input  logic rx_en_i,
  output logic pad_out_o,
  output logic pad_oe_o
);
  owner_e owner;

  always_comb begin
    if (tmr_en_i)      owner = OWN_TMR;
    else if (pwm_en_i) owner = OWN_PWM;
    else if (tx_en_i)  owner = OWN_TX;
    else if (rx_en_i)  owner = OWN_RX;
    else               owner = OWN_GPIO;
  end

  always_comb begin
    unique case (owner)
      OWN_TMR: begin pad_out_o = tmr_out_i;  pad_oe_o = 1'b1; end
      OWN_PWM: begin pad_out_o = pwm_out_i;  pad_oe_o = 1'b1; end
      OWN_TX:  begin pad_out_o = tx_i;       pad_oe_o = 1'b1; end
      OWN_RX:  begin pad_out_o = 1'b0;       pad_oe_o = 1'b0; end
      default: begin pad_out_o = gpio_out_i; pad_oe_o = gpio_oe_i; end
    endcase
  end
endmodule

// File: rtl/gpio_alt_port.sv
module gpio_alt_port #(
  parameter int          NPINS     = 4,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 8,
  parameter logic [11:0] DATA_ADDR = 12'h250,
  parameter logic [11:0] DIR_ADDR  = 12'h252,
  parameter int          TX_PIN    = 1,
  parameter int          RX_PIN    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NPINS-1:0]  pad_in_i,
  output logic [NPINS-1:0]  pad_out_o,
  output logic [NPINS-1:0]  pad_oe_o,
  input  logic [NPINS-1:0]  tmr_en_i,
  input  logic [NPINS-1:0]  tmr_out_i,
  input  logic [NPINS-1:0]  pwm_en_i,
  input  logic [NPINS-1:0]  pwm_out_i,
  input  logic              ser_tx_en_i,
  input  logic              ser_tx_i,
  input  logic              ser_rx_en_i,
  output logic              ser_rx_o
);
  logic [NPINS-1:0] data_q, dir_q;

  gpio_port_regs #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR)
  ) i_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .we_i     (we_i),
    .wdata_i  (wdata_i),
    .pad_in_i (pad_in_i),
    .data_q_o (data_q),
    .dir_q_o  (dir_q),
    .rdata_o  (rdata_o)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic tx_en, rx_en;
    assign tx_en = (i == TX_PIN) ? ser_tx_en_i : 1'b0;
    assign rx_en = (i == RX_PIN) ? ser_rx_en_i : 1'b0;

    gpio_pin_mux i_mux (
      .gpio_out_i (data_q[i]),
      .gpio_oe_i  (dir_q[i]),
      .tmr_en_i   (tmr_en_i[i]),
      .tmr_out_i  (tmr_out_i[i]),
      .pwm_en_i   (pwm_en_i[i]),
      .pwm_out_i  (pwm_out_i[i]),
      .tx_en_i    (tx_en),
      .tx_i       (ser_tx_i),
      .rx_en_i    (rx_en),
      .pad_out_o  (pad_out_o[i]),
      .pad_oe_o   (pad_oe_o[i])
    );
  end

  assign ser_rx_o = pad_in_i[RX_PIN];
endmodule

// File: rtl/gpio_alt_port_chk.sv
module gpio_alt_port_chk #(
  parameter int          NPINS     = 4,
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 8,
  parameter logic [11:0] DATA_ADDR = 12'h250
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  pad_out_o,
  input logic [NPINS-1:0]  pad_oe_o,
  input logic [NPINS-1:0]  tmr_en_i,
  input logic [NPINS-1:0]  tmr_out_i,
  input logic [NPINS-1:0]  pwm_en_i,
  input logic [NPINS-1:0]  pwm_out_i,
  input logic              ser_rx_en_i
);
  // R1
  data_write_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(we_i && addr_i == ADDR_W'(DATA_ADDR)) && addr_i == ADDR_W'(DATA_ADDR) && dir_q == '1)
      |-> rdata_o[NPINS-1:0] == $past(wdata_i[NPINS-1:0]));

  // R2
  reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_W'(DATA_ADDR)) |-> rdata_o[DATA_W-1:NPINS] == '0);

  // R7
  tmr_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((tmr_en_i & ~pad_oe_o) == '0) && (((pad_out_o ^ tmr_out_i) & tmr_en_i) == '0));

  // R8
  pwm_priority_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pwm_en_i & ~tmr_en_i & ~pad_oe_o) == '0) &&
    (((pad_out_o ^ pwm_out_i) & pwm_en_i & ~tmr_en_i) == '0));

  // R10
  rx_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ser_rx_en_i && !tmr_en_i[0] && !pwm_en_i[0]) |-> !pad_oe_o[0]);
endmodule

bind gpio_alt_port gpio_alt_port_chk #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DATA_ADDR(DATA_ADDR)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .addr_i      (addr_i),
  .we_i        (we_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .dir_q       (dir_q),
  .pad_out_o   (pad_out_o),
  .pad_oe_o    (pad_oe_o),
  .tmr_en_i    (tmr_en_i),
  .tmr_out_i   (tmr_out_i),
  .pwm_en_i    (pwm_en_i),
  .pwm_out_i   (pwm_out_i),
  .ser_rx_en_i (ser_rx_en_i)
);

// File: tb/test_gpio_alt_port.sv
module test_gpio_alt_port;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [3:0]  pad_in_i = '0;
  logic [3:0]  pad_out_o, pad_oe_o;
  logic [3:0]  tmr_en_i = '0, tmr_out_i = '0, pwm_en_i = '0, pwm_out_i = '0;
  logic        ser_tx_en_i = 1'b0, ser_tx_i = 1'b0, ser_rx_en_i = 1'b0;
  logic        ser_rx_o;

  int n_chk = 0;
  int n_bad = 0;

  gpio_alt_port i_gpio_alt_port (.*);

  always #5 clk_i = ~clk_i;

  // {tmr_en, tmr_out, pwm_en, pwm_out, tx_en, tx, rx_en, exp_out, exp_oe}; latch=1010, dir=1111
  localparam int NV = 6;
  localparam logic [26:0] VEC [NV] = '{
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b0, 1'b0, 1'b0, 4'b1010, 4'b1111}, // R6
    {4'b1111, 4'b0101, 4'b1111, 4'b1111, 1'b1, 1'b1, 1'b1, 4'b0101, 4'b1111}, // R7
    {4'b0000, 4'b0000, 4'b1100, 4'b0100, 1'b0, 1'b0, 1'b0, 4'b0110, 4'b1111}, // R8
    {4'b0010, 4'b0000, 4'b0001, 4'b0001, 1'b1, 1'b1, 1'b0, 4'b1001, 4'b1111}, // R7 R8
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 1'b1, 1'b0, 1'b1, 4'b1000, 4'b1110}, // R9 R10
    {4'b0000, 4'b0000, 4'b0011, 4'b0000, 1'b1, 1'b1, 1'b1, 4'b1000, 4'b1111}  // R8
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic clear_periph();
    tmr_en_i = '0; tmr_out_i = '0; pwm_en_i = '0; pwm_out_i = '0;
    ser_tx_en_i = 1'b0; ser_tx_i = 1'b0; ser_rx_en_i = 1'b0;
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    check("R4 oe after reset", {4'b0, pad_oe_o}, 8'h00);
    rd(12'h252, r);
    check("R4 dir reset", r, 8'h00);

    wr(12'h250, 8'hFA);
    wr(12'h252, 8'h0F);
    rd(12'h250, r);
    check("R1 R2 readback", r, 8'h0A);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {tmr_en_i, tmr_out_i, pwm_en_i, pwm_out_i, ser_tx_en_i, ser_tx_i, ser_rx_en_i} = VEC[i][26:8];
      #1;
      check("R6-R10 vector out", {4'b0, pad_out_o}, {4'b0, VEC[i][7:4]});
      check("R6-R10 vector oe",  {4'b0, pad_oe_o},  {4'b0, VEC[i][3:0]});
    end
    clear_periph();

    // R5: pins 3,2 input, 1,0 output
    wr(12'h252, 8'h03);
    pad_in_i = 4'b0101;
    rd(12'h250, r);
    check("R5 mixed read", r, 8'h06);
    #1 check("R6 oe follows dir", {4'b0, pad_oe_o}, 8'h03);

    // R10: receive data tracks pad 0
    ser_rx_en_i = 1'b1;
    pad_in_i = 4'b0001;
    #1 check("R10 rx high", {7'b0, ser_rx_o}, 8'h01);
    pad_in_i = 4'b0000;
    #1 check("R10 rx low", {7'b0, ser_rx_o}, 8'h00);
    ser_rx_en_i = 1'b0;

    // R3: latch survives reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    wr(12'h252, 8'h0F);
    rd(12'h250, r);
    check("R3 latch kept", r, 8'h0A);

    // R11: write while timer owns all pins
    @(negedge clk_i);
    tmr_en_i = 4'hF; tmr_out_i = 4'b0011;
    wr(12'h250, 8'h05);
    #1 check("R11 timer still drives", {4'b0, pad_out_o}, 8'h03);
    tmr_en_i = 4'h0;
    #1 check("R11 new latch visible", {4'b0, pad_out_o}, 8'h05);

    // R12: unmapped offset
    wr(12'h260, 8'hFF);
    rd(12'h260, r);
    check("R12 unmapped read", r, 8'h00);
    rd(12'h250, r);
    check("R12 data untouched", r, 8'h05);
    rd(12'h252, r);
    check("R12 dir untouched", r, 8'h0F);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule